// File: doc/BRIEF.md
# Register-Condition Branch Unit

This block resolves conditional branches that compare one whole 64-bit register with zero. It does not read condition flags. It serves a 64-bit core whose branches have a single delay slot. Each cycle it can accept a decoded branch word, the value read for the tested register, the address of the branch (PC) and the address of the instruction after it (NPC). One cycle later it returns three things: the address to fetch after the delay slot (NNPC), a taken flag, and an annul flag that tells the pipeline to squash the delay-slot instruction.

The 16-bit word displacement is carried in two separate pieces of the instruction. The block joins the pieces, sign-extends the result, scales it to bytes and adds it to the PC of the branch. An illegal flag marks encodings that use a reserved condition value or have the must-be-zero bit set. Such a branch never redirects fetch. The prediction hint bit is carried in the word, but it has no effect on any result.

Top module: `rcb_branch_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted branch, out_valid, taken, annul, illegal and nnpc are all zero.
- R2: The condition is taken from instr[27:25], and rs1_val is read as a signed 64-bit number. Code 1 is true when rs1_val is zero. Code 5 is true when it is nonzero. Code 3 is true when it is negative. Code 7 is true when it is zero or positive. Code 2 is true when it is zero or negative. Code 6 is true when it is strictly positive.
- R3: The displacement is {instr[21:20], instr[13:0]}, taken as a signed 16-bit word count. A taken branch gives nnpc = pc + (sign-extended displacement × 4).
- R4: annul is 1 exactly when the branch is not taken and the annul bit instr[29] is 1. A taken branch always gives annul = 0.
- R5: A branch that is not taken gives nnpc = npc + 4, whether or not it is annulled.
- R6: Condition codes 0 and 4 raise illegal, and the branch is not taken.
- R7: The reserved bit instr[28] set to 1 raises illegal, and the branch is not taken, whatever the condition.
- R8: out_valid is in_valid delayed by one clock. The other outputs load only on a cycle with in_valid high, and they hold their values otherwise.
- R9: The hint bit instr[19] has no effect on nnpc, taken, annul or illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | A branch is presented this cycle |
| instr | input | 32 | Decoded branch instruction word |
| rs1_val | input | 64 | Value of the tested register |
| pc | input | 64 | Address of the branch |
| npc | input | 64 | Address of the delay-slot instruction |
| out_valid | output | 1 | Result of the branch accepted one cycle earlier |
| nnpc | output | 64 | Fetch address after the delay slot |
| taken | output | 1 | Branch redirects to its target |
| annul | output | 1 | Squash the delay-slot instruction |
| illegal | output | 1 | Reserved condition code or reserved bit set |

## Verification
The checker assumes that every word presented with in_valid high has already been classed as a register-condition branch by the decoder. It also assumes that npc and pc are stable inputs sampled on the same edge as the word. Its fall-through and zero-test properties look one cycle back, so they depend on the single-register latency and are enabled only in that variant. The bench changes inputs only on the falling edge and holds in_valid low during reset. It chooses pc and npc as aligned addresses well away from the 64-bit wrap, which keeps the target and fall-through sums free of overflow.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
   // Field positions that the instruction decoder and this unit share
   localparam int ANNUL_POS = 29;
   localparam int RSV_POS   = 28;
   localparam int COND_LSB  = 25;
   localparam int COND_W    = 3;
   localparam int HINT_POS  = 19;
   localparam int DHI_LSB   = 20;
   localparam int DLO_LSB   = 0;

   typedef enum logic [COND_W-1:0] {
      RC_RSV_A = 3'd0,
      RC_EQZ   = 3'd1,
      RC_LEZ   = 3'd2,
      RC_LTZ   = 3'd3,
      RC_RSV_B = 3'd4,
      RC_NEZ   = 3'd5,
      RC_GTZ   = 3'd6,
      RC_GEZ   = 3'd7
   } rcond_e;

   typedef struct packed {
      logic   annul_req;
      logic   rsv_set;
      rcond_e cond;
   } ctl_fields_t;
endpackage

// File: rtl/rcb_field_split.sv
module rcb_field_split
   import rcb_pkg::*;
#(
   parameter int ILEN = 32,
   parameter int HI_W = 2,
   parameter int LO_W = 14
) (
   input  logic [ILEN-1:0] instr,
   output ctl_fields_t     ctl,
   output logic [HI_W-1:0] disp_hi,
   output logic [LO_W-1:0] disp_lo
);
   localparam int TOP_USED = ANNUL_POS;

   if (ILEN <= TOP_USED) begin : g_bad_ilen
      $error("rcb_field_split: ILEN too small for field layout");
   end
   if (DLO_LSB + LO_W > HINT_POS) begin : g_bad_lo
      $error("rcb_field_split: low displacement overlaps hint bit");
   end

   always_comb begin
      ctl.annul_req = instr[ANNUL_POS];
      ctl.rsv_set   = instr[RSV_POS];
      ctl.cond      = rcond_e'(instr[COND_LSB +: COND_W]);
   end

   assign disp_hi = instr[DHI_LSB +: HI_W];
   assign disp_lo = instr[DLO_LSB +: LO_W];

   // The hint, op2, register index and top bits are never examined
   logic unused_bits;
   assign unused_bits = ^{instr[ILEN-1:ANNUL_POS+1], instr[COND_LSB-1:DHI_LSB+HI_W],
                          instr[HINT_POS:DLO_LSB+LO_W]};
endmodule

// File: rtl/rcb_cond_eval.sv
module rcb_cond_eval
   import rcb_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  rcond_e          cond,
   input  logic            rsv_set,
   input  logic [XLEN-1:0] rs1_val,
   output logic            take,
   output logic            bad_enc
);
   if (XLEN < 2) begin : g_bad_xlen
      $error("rcb_cond_eval: XLEN must be at least 2");
   end

   logic is_zero;
   logic is_neg;
   logic hit;

   assign is_zero = (rs1_val == '0);
   assign is_neg  = rs1_val[XLEN-1];

   always_comb begin
      unique case (cond)
         RC_EQZ:  hit = is_zero;
         RC_NEZ:  hit = !is_zero;
         RC_LTZ:  hit = is_neg;
         RC_GEZ:  hit = !is_neg;
         RC_LEZ:  hit = is_neg || is_zero;
         RC_GTZ:  hit = !is_neg && !is_zero;
         default: hit = 1'b0;
      endcase
   end

   assign bad_enc = rsv_set || (cond == RC_RSV_A) || (cond == RC_RSV_B);
   assign take    = hit && !bad_enc;
endmodule

// File: rtl/rcb_target_calc.sv
module rcb_target_calc #(
   parameter int XLEN       = 64,
   parameter int HI_W       = 2,
   parameter int LO_W       = 14,
   parameter int WORD_SHIFT = 2
) (
   input  logic [HI_W-1:0] disp_hi,
   input  logic [LO_W-1:0] disp_lo,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] npc,
   output logic [XLEN-1:0] target,
   output logic [XLEN-1:0] fallthru
);
   localparam int DISP_W = HI_W + LO_W;
   localparam int EXT_W  = XLEN - DISP_W - WORD_SHIFT;
   localparam int STEP   = 1 << WORD_SHIFT;

   if (EXT_W < 1) begin : g_bad_widths
      $error("rcb_target_calc: XLEN too small for displacement");
   end

   logic [DISP_W-1:0] disp;
   logic [XLEN-1:0]   offset;

   assign disp   = {disp_hi, disp_lo};
   assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, {WORD_SHIFT{1'b0}}};

   assign target   = pc + offset;
   assign fallthru = npc + XLEN'(STEP);
endmodule

// File: rtl/rcb_branch_unit.sv
module rcb_branch_unit
   import rcb_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int ILEN       = 32,
   parameter int HI_W       = 2,
   parameter int LO_W       = 14,
   parameter int WORD_SHIFT = 2,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [ILEN-1:0] instr,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] npc,
   output logic            out_valid,
   output logic [XLEN-1:0] nnpc,
   output logic            taken,
   output logic            annul,
   output logic            illegal
);
   if (HI_W + LO_W != 16) begin : g_bad_disp
      $error("rcb_branch_unit: displacement pieces must total 16 bits");
   end

   ctl_fields_t     ctl;
   logic [HI_W-1:0] d_hi;
   logic [LO_W-1:0] d_lo;
   logic            c_take;
   logic            c_bad;
   logic [XLEN-1:0] c_target;
   logic [XLEN-1:0] c_fall;
   logic [XLEN-1:0] c_nnpc;
   logic            c_annul;

   rcb_field_split #(.ILEN(ILEN), .HI_W(HI_W), .LO_W(LO_W)) i_split (
      .instr   (instr),
      .ctl     (ctl),
      .disp_hi (d_hi),
      .disp_lo (d_lo)
   );

   rcb_cond_eval #(.XLEN(XLEN)) i_cond (
      .cond    (ctl.cond),
      .rsv_set (ctl.rsv_set),
      .rs1_val (rs1_val),
      .take    (c_take),
      .bad_enc (c_bad)
   );

   rcb_target_calc #(
      .XLEN(XLEN), .HI_W(HI_W), .LO_W(LO_W), .WORD_SHIFT(WORD_SHIFT)
   ) i_tgt (
      .disp_hi  (d_hi),
      .disp_lo  (d_lo),
      .pc       (pc),
      .npc      (npc),
      .target   (c_target),
      .fallthru (c_fall)
   );

   assign c_nnpc  = c_take ? c_target : c_fall;
   assign c_annul = ctl.annul_req && !c_take;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            nnpc      <= '0;
            taken     <= 1'b0;
            annul     <= 1'b0;
            illegal   <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               nnpc    <= c_nnpc;
               taken   <= c_take;
               annul   <= c_annul;
               illegal <= c_bad;
            end
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign nnpc       = in_valid ? c_nnpc  : '0;
      assign taken      = in_valid && c_take;
      assign annul      = in_valid && c_annul;
      assign illegal    = in_valid && c_bad;
   end
endmodule

// File: rtl/rcb_branch_unit_chk.sv
module rcb_branch_unit_chk #(
   parameter int XLEN    = 64,
   parameter int ILEN    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [ILEN-1:0] instr,
   input logic [XLEN-1:0] rs1_val,
   input logic [XLEN-1:0] npc,
   input logic            out_valid,
   input logic [XLEN-1:0] nnpc,
   input logic            taken,
   input logic            annul,
   input logic            illegal
);
   a_r4_annul_only_untaken: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && annul |-> !taken);

   a_r4_taken_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && taken |-> !annul);

   a_r6_illegal_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && illegal |-> !taken);

   if (REG_OUT) begin : g_seq
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (taken || nnpc == $past(npc) + XLEN'(4)));

      a_r2_zero_taken: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && !instr[28] && instr[27:25] == 3'd1 && rs1_val == '0 |=> taken);

      a_r7_reserved_bit: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && instr[28] |=> illegal && !taken);
   end
endmodule

bind rcb_branch_unit rcb_branch_unit_chk #(
   .XLEN(XLEN), .ILEN(ILEN), .REG_OUT(REG_OUT)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .rs1_val   (rs1_val),
   .npc       (npc),
   .out_valid (out_valid),
   .nnpc      (nnpc),
   .taken     (taken),
   .annul     (annul),
   .illegal   (illegal)
);

// File: tb/test_rcb_branch_unit.sv
`timescale 1ns/1ps
module test_rcb_branch_unit;
   localparam int XLEN = 64;
   localparam int NV   = 18;

   typedef struct packed {
      logic [2:0]  cond;
      logic        a;
      logic        rsv;
      logic        hint;
      logic [15:0] disp;
      logic [63:0] rs1;
      logic        e_taken;
      logic        e_annul;
      logic        e_ill;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{3'd1, 1'b0, 1'b0, 1'b0, 16'h0010, 64'h0, 1'b1, 1'b0, 1'b0},
      '{3'd1, 1'b1, 1'b0, 1'b0, 16'h0010, 64'h5, 1'b0, 1'b1, 1'b0},
      '{3'd2, 1'b0, 1'b0, 1'b0, 16'hFFF0, 64'h0, 1'b1, 1'b0, 1'b0},
      '{3'd2, 1'b0, 1'b0, 1'b1, 16'h0004, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0},
      '{3'd2, 1'b1, 1'b0, 1'b0, 16'h0004, 64'h1, 1'b0, 1'b1, 1'b0},
      '{3'd3, 1'b0, 1'b0, 1'b0, 16'h8000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0},
      '{3'd3, 1'b1, 1'b0, 1'b0, 16'h0004, 64'h0, 1'b0, 1'b1, 1'b0},
      '{3'd5, 1'b1, 1'b0, 1'b0, 16'h7FFF, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0},
      '{3'd5, 1'b0, 1'b0, 1'b0, 16'h0004, 64'h0, 1'b0, 1'b0, 1'b0},
      '{3'd6, 1'b0, 1'b0, 1'b0, 16'h4000, 64'h1, 1'b1, 1'b0, 1'b0},
      '{3'd6, 1'b1, 1'b0, 1'b0, 16'h0004, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
      '{3'd6, 1'b0, 1'b0, 1'b0, 16'h0004, 64'h0, 1'b0, 1'b0, 1'b0},
      '{3'd7, 1'b0, 1'b0, 1'b0, 16'hC000, 64'h0, 1'b1, 1'b0, 1'b0},
      '{3'd7, 1'b1, 1'b0, 1'b1, 16'h0004, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0},
      '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0004, 64'h0, 1'b0, 1'b1, 1'b1},
      '{3'd4, 1'b0, 1'b0, 1'b0, 16'h0004, 64'h0, 1'b0, 1'b0, 1'b1},
      '{3'd1, 1'b0, 1'b1, 1'b0, 16'h0004, 64'h0, 1'b0, 1'b0, 1'b1},
      '{3'd7, 1'b1, 1'b0, 1'b0, 16'h0020, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [XLEN-1:0] rs1_val = '0;
   logic [XLEN-1:0] pc = '0;
   logic [XLEN-1:0] npc = '0;
   logic            out_valid;
   logic [XLEN-1:0] nnpc;
   logic            taken;
   logic            annul;
   logic            illegal;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rcb_branch_unit i_rcb_branch_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .rs1_val(rs1_val), .pc(pc), .npc(npc), .out_valid(out_valid),
      .nnpc(nnpc), .taken(taken), .annul(annul), .illegal(illegal)
   );

   function automatic logic [31:0] mk(input logic a, input logic rsv, input logic [2:0] c,
                                      input logic h, input logic [15:0] d);
      logic [31:0] w;
      w        = 32'h0;
      w[30]    = 1'b0;
      w[29]    = a;
      w[28]    = rsv;
      w[27:25] = c;
      w[24:22] = 3'b011;
      w[21:20] = d[15:14];
      w[19]    = h;
      w[18:14] = 5'd9;
      w[13:0]  = d[13:0];
      return w;
   endfunction

   function automatic logic [63:0] exp_next(input logic t, input logic [15:0] d,
                                            input logic [63:0] p, input logic [63:0] n);
      logic signed [63:0] off;
      off = 64'(signed'(d)) * 4;
      return t ? p + off : n + 64'd4;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] w, input logic [63:0] r, input logic [63:0] p);
      @(negedge clk);
      instr    = w;
      rs1_val  = r;
      pc       = p;
      npc      = p + 64'd4;
      in_valid = 1'b1;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] save_nnpc;
      logic [2:0]  save_flags;
      // R1: reset values
      repeat (3) @(posedge clk);
      #1;
      chk("R1 out_valid", 64'(out_valid), 64'd0);
      chk("R1 nnpc", nnpc, 64'd0);
      chk("R1 flags", 64'({taken, annul, illegal}), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 after release", 64'({out_valid, taken, annul, illegal}), 64'd0);

      // R2..R7 table walk
      for (int i = 0; i < NV; i++) begin
         logic [63:0] p;
         p = 64'h0000_0000_0010_0000 + 64'(i) * 64'h100;
         issue(mk(VEC[i].a, VEC[i].rsv, VEC[i].cond, VEC[i].hint, VEC[i].disp), VEC[i].rs1, p);
         chk("R8 valid", 64'(out_valid), 64'd1);
         chk("R2/R6/R7 taken", 64'(taken), 64'(VEC[i].e_taken));
         chk("R4 annul", 64'(annul), 64'(VEC[i].e_annul));
         chk("R6/R7 illegal", 64'(illegal), 64'(VEC[i].e_ill));
         chk("R3/R5 nnpc", nnpc, exp_next(VEC[i].e_taken, VEC[i].disp, p, p + 64'd4));
      end

      // R8: hold while idle
      save_nnpc  = nnpc;
      save_flags = {taken, annul, illegal};
      @(negedge clk);
      in_valid = 1'b0;
      instr    = mk(1'b1, 1'b1, 3'd0, 1'b0, 16'h1234);
      pc       = 64'h9999_0000;
      @(posedge clk);
      #1;
      chk("R8 out_valid drops", 64'(out_valid), 64'd0);
      chk("R8 nnpc held", nnpc, save_nnpc);
      chk("R8 flags held", 64'({taken, annul, illegal}), 64'(save_flags));

      // R9: hint toggles give identical results
      for (int h = 0; h < 2; h++) begin
         issue(mk(1'b1, 1'b0, 3'd6, h[0], 16'hFFFE), 64'h0, 64'h0000_0000_0020_0000);
         chk("R9 hint nnpc", nnpc, 64'h0000_0000_0020_0004 + 64'd4);
         chk("R9 hint flags", 64'({taken, annul, illegal}), 64'b010);
         issue(mk(1'b0, 1'b0, 3'd6, h[0], 16'hFFFE), 64'h3, 64'h0000_0000_0020_0000);
         chk("R9 hint taken nnpc", nnpc, 64'h0000_0000_0020_0000 - 64'd8);
      end

      // R3: largest positive and most negative offsets on a zero test
      issue(mk(1'b0, 1'b0, 3'd1, 1'b0, 16'h7FFF), 64'h0, 64'h0000_0000_0100_0000);
      chk("R3 max disp", nnpc, 64'h0000_0000_0100_0000 + 64'h1FFFC);
      issue(mk(1'b0, 1'b0, 3'd1, 1'b0, 16'h8000), 64'h0, 64'h0000_0000_0100_0000);
      chk("R3 min disp", nnpc, 64'h0000_0000_0100_0000 - 64'h20000);

      @(negedge clk);
      in_valid = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule